// File: doc/BRIEF.md
# Phase-Tagged Sample Capture with Square-Wave Sync

This block takes ADC samples at a fixed rate and sends out a square wave that stays locked to that rate. One free-running divider produces both. The divider makes a sample tick every `CLK_PER_TICK` clock cycles. A position counter advances once per tick and wraps after `TICKS_PER_CYCLE` ticks. The sync output is high while the position is below `HIGH_TICKS` and low for the rest of the cycle. With the defaults (100 MHz clock, 1000 cycles per tick, 1000 ticks per cycle, 500 high), this gives 100 kS/s and a 100 Hz sync wave with a 50 % duty cycle.

On every tick the block writes two words into an internal FIFO: first the position word, then the ADC word. The host raises `run_en` to start a capture, and each start begins at position 0. The capture ends when `target_count` ticks have occurred or when `run_en` drops. A pair is only written when the FIFO has room for both of its words. If there is no room, the block skips the whole pair and sets a sticky overflow flag. Because a pair is never split, the stream a reader sees stays aligned. A synchronous `clear` empties the FIFO and discards any leftover words.

Top module: `phase_tag_sampler`

## Requirements
- R1: While capturing, a tick occurs every `CLK_PER_TICK` cycles. The first tick is in the cycle right after the clock edge at which `run_en` is first seen high.
- R2: The position word of tick k (counting from 0 since the start) holds k mod `TICKS_PER_CYCLE`, zero-extended into bits 15:0. Its bit 16 is 1. The first pair of every capture therefore carries position 0.
- R3: `sync_out` is high while capturing and the current position is below `HIGH_TICKS`. It is low otherwise, and it is low whenever the block is idle.
- R4: Each pair is written in a fixed order. The position word (bit 16 = 1) is written in the tick cycle. The sample word (bit 16 = 0) is written in the cycle after it.
- R5: The sample word holds `adc_data` from the tick cycle if `adc_valid` is high in that cycle. Otherwise it holds the last word that was presented with `adc_valid` high.
- R6: No word is written while `run_en` is low. Dropping `run_en` ends the capture. Raising it again starts a fresh capture at position 0.
- R7: After `target_count` ticks, capture stops, no further pairs are written, and `done` goes high and stays high until the next start or a clear. A start with `target_count` = 0 sets `done` at once and writes nothing.
- R8: A pair is written only if at least two FIFO entries are free. Otherwise both words are skipped and `overflow` is set. `overflow` stays set until `clear`, and the FIFO is never written while full.
- R9: `clear` empties the FIFO, drops `overflow` and `done`, and stops any capture.
- R10: The FIFO is show-ahead. `rd_data` presents the oldest stored word, and `rd_en` removes that word at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of the FIFO and the control state |
| run_en | input | 1 | Host capture enable; a rising level starts a capture |
| target_count | input | CNT_W | Number of ticks to capture |
| adc_data | input | DATA_W | ADC sample word |
| adc_valid | input | 1 | Qualifies `adc_data` |
| sync_out | output | 1 | Square-wave sync output |
| rd_en | input | 1 | Removes the word shown on `rd_data` |
| rd_data | output | DATA_W+1 | Oldest FIFO word; bit 16 = 1 marks a position word |
| rd_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds `FIFO_DEPTH` words |
| overflow | output | 1 | Sticky: a pair was skipped for lack of room |
| done | output | 1 | The requested tick count has been reached |

## Verification
The bench uses a small configuration (4-cycle ticks, 6-tick sync cycle, 8-entry FIFO). It sweeps every cycle of a capture that wraps the position counter. A divider that is off by one would shift the sample indices and the sync edges, and a position counter that skips its reset on start would tag the first pair with a non-zero position.

It then stops a capture early and restarts it, runs with `adc_valid` held low, and runs with a zero target. A design that latched stale data or kept running after stop would produce extra or wrong words. Finally it fills the FIFO past its capacity. A design that wrote half a pair would leave an odd word count or a misplaced tag, and one that cleared the overflow flag early would lose the evidence of the skipped pairs.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Advance a counter that wraps to zero after reaching `last`.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Level of the square wave at a given position in its cycle.
  function automatic logic sync_level(input int unsigned pos, input int unsigned high_ticks);
    return pos < high_ticks;
  endfunction

  // True if a FIFO holding `level` words can take a whole pair.
  function automatic logic pair_fits(input int unsigned level, input int unsigned depth);
    return (level + 2) <= depth;
  endfunction

endpackage

// File: rtl/pts_tick_gen.sv
module pts_tick_gen #(
  parameter int unsigned CLK_PER_TICK    = 1000,
  parameter int unsigned TICKS_PER_CYCLE = 1000,
  parameter int unsigned HIGH_TICKS      = 500,
  parameter int unsigned PH_W            = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic            tick,
  output logic [PH_W-1:0] phase,
  output logic            sync
);
  localparam int unsigned DIV_W = $clog2(CLK_PER_TICK);

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  phase_q;
  logic             period_end;

  assign period_end = (div_q == DIV_W'(CLK_PER_TICK - 1));

  // Both counters rest at zero while idle, so every start begins a fresh cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (!run) begin
      div_q   <= '0;
      phase_q <= '0;
    end else begin
      div_q <= DIV_W'(pts_pkg::wrap_inc(32'(div_q), CLK_PER_TICK - 1));
      if (period_end)
        phase_q <= PH_W'(pts_pkg::wrap_inc(32'(phase_q), TICKS_PER_CYCLE - 1));
    end
  end

  assign tick  = run && (div_q == '0);
  assign phase = phase_q;
  assign sync  = run && pts_pkg::sync_level(32'(phase_q), HIGH_TICKS);
endmodule

// File: rtl/pts_pair_fifo.sv
module pts_pair_fifo #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned WW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          pair_room
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] level_q;
  logic          do_wr, do_rd;

  assign empty     = (level_q == '0);
  assign full      = (level_q == LW'(DEPTH));
  assign do_wr     = wr_en && !full;
  assign do_rd     = rd_en && !empty;
  assign rd_data   = mem[rp_q];
  assign pair_room = pts_pkg::pair_fits(32'(level_q), DEPTH);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else if (flush) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/pts_capture_ctl.sv
module pts_capture_ctl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned PH_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run_en,
  input  logic [CNT_W-1:0]  target,
  input  logic              tick,
  input  logic [PH_W-1:0]   phase,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_valid,
  input  logic              room,
  output logic              active,
  output logic              pos_write,
  output logic              skip_pair,
  output logic              wr_en,
  output logic [DATA_W:0]   wr_data,
  output logic              overflow,
  output logic              done
);
  logic              run_q, active_q, pend_q, ovf_q, done_q;
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] last_q, hold_q, sample_now;
  logic              start, take, last_tick;

  assign start      = run_en && !run_q;
  assign take       = tick && active_q;
  assign pos_write  = take && room;
  assign skip_pair  = take && !room;
  assign last_tick  = take && (count_q + 1'b1 == target);
  assign sample_now = adc_valid ? adc_data : last_q;

  // Position word in the tick cycle, sample word in the following one.
  assign wr_en   = pos_write || pend_q;
  assign wr_data = pend_q ? {1'b0, hold_q} : {1'b1, DATA_W'(phase)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      hold_q <= '0;
    end else begin
      if (adc_valid) last_q <= adc_data;
      if (pos_write) hold_q <= sample_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
      count_q  <= '0;
    end else begin
      run_q <= run_en;
      if (clear) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
        ovf_q    <= 1'b0;
        done_q   <= 1'b0;
        count_q  <= '0;
      end else begin
        pend_q <= pos_write;
        if (skip_pair) ovf_q <= 1'b1;
        if (start) begin
          active_q <= (target != '0);
          done_q   <= (target == '0);
          count_q  <= '0;
        end else if (!run_en) begin
          active_q <= 1'b0;
        end else if (take) begin
          count_q <= count_q + 1'b1;
          if (last_tick) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign active   = active_q;
  assign overflow = ovf_q;
  assign done     = done_q;
endmodule

// File: rtl/phase_tag_sampler.sv
module phase_tag_sampler #(
  parameter int unsigned CLK_PER_TICK    = 1000,
  parameter int unsigned TICKS_PER_CYCLE = 1000,
  parameter int unsigned HIGH_TICKS      = 500,
  parameter int unsigned FIFO_DEPTH      = 4096,
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned CNT_W           = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run_en,
  input  logic [CNT_W-1:0]  target_count,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_valid,
  output logic              sync_out,
  input  logic              rd_en,
  output logic [DATA_W:0]   rd_data,
  output logic              rd_empty,
  output logic              fifo_full,
  output logic              overflow,
  output logic              done
);
  localparam int unsigned PH_W = $clog2(TICKS_PER_CYCLE);
  localparam int unsigned WW   = DATA_W + 1;

  logic            active, tick, room, pos_write, skip_pair, wr_en, wr_tag;
  logic [PH_W-1:0] phase;
  logic [WW-1:0]   wr_data;

  pts_tick_gen #(
    .CLK_PER_TICK(CLK_PER_TICK), .TICKS_PER_CYCLE(TICKS_PER_CYCLE),
    .HIGH_TICKS(HIGH_TICKS), .PH_W(PH_W)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active),
    .tick(tick), .phase(phase), .sync(sync_out)
  );

  pts_capture_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PH_W(PH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run_en(run_en),
    .target(target_count), .tick(tick), .phase(phase),
    .adc_data(adc_data), .adc_valid(adc_valid), .room(room),
    .active(active), .pos_write(pos_write), .skip_pair(skip_pair),
    .wr_en(wr_en), .wr_data(wr_data), .overflow(overflow), .done(done)
  );

  pts_pair_fifo #(.DEPTH(FIFO_DEPTH), .WW(WW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .empty(rd_empty), .full(fifo_full), .pair_room(room)
  );

  assign wr_tag = wr_data[WW-1];
endmodule

// File: rtl/pts_checker.sv
module pts_checker (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic run_en,
  input logic active,
  input logic tick,
  input logic pos_write,
  input logic skip_pair,
  input logic wr_en,
  input logic wr_tag,
  input logic fifo_full,
  input logic overflow,
  input logic sync_out
);
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_sync_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sync_out);

  assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_write && !clear) |=> (wr_en && !wr_tag));

  assert_tag_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_write |-> wr_tag);

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_write |-> $past(run_en));

  assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fifo_full);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  assert_skip_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_pair && !clear) |=> overflow);

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!overflow && !active));
endmodule

bind phase_tag_sampler pts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .run_en(run_en),
  .active(active), .tick(tick), .pos_write(pos_write), .skip_pair(skip_pair),
  .wr_en(wr_en), .wr_tag(wr_tag), .fifo_full(fifo_full),
  .overflow(overflow), .sync_out(sync_out)
);

// File: tb/sim_phase_tag_sampler.sv
module sim_phase_tag_sampler;
  localparam int CPT = 4;
  localparam int TPC = 6;
  localparam int HT  = 3;
  localparam int DEP = 8;
  localparam int DW  = 16;
  localparam int CW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          run_en = 1'b0;
  logic [CW-1:0] target_count = '0;
  logic [DW-1:0] adc_data = '0;
  logic          adc_valid = 1'b0;
  logic          sync_out, rd_en, rd_empty, fifo_full, overflow, done;
  logic [DW:0]   rd_data;

  int checks = 0, errors = 0;
  int idx = 0, wcnt = 0, sync_lim = -1;
  bit drain = 0, vld_mode = 1, sync_chk = 0;
  logic [DW:0] words [64];

  always #5 clk = ~clk;

  phase_tag_sampler #(
    .CLK_PER_TICK(CPT), .TICKS_PER_CYCLE(TPC), .HIGH_TICKS(HT),
    .FIFO_DEPTH(DEP), .DATA_W(DW), .CNT_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run_en(run_en),
    .target_count(target_count), .adc_data(adc_data), .adc_valid(adc_valid),
    .sync_out(sync_out), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
    .fifo_full(fifo_full), .overflow(overflow), .done(done)
  );

  initial rd_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle per call: drive ADC, check sync, drain one word if asked.
  task automatic cycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      adc_data  = 16'hA000 + 16'(idx);
      adc_valid = vld_mode;
      if (sync_chk) begin
        bit e;
        e = (idx <= sync_lim) ? (((idx / CPT) % TPC) < HT) : 1'b0;
        chk(sync_out == e, "R3", "sync_out", int'(sync_out), int'(e));
      end
      if (drain && !rd_empty) begin
        if (wcnt < 64) words[wcnt] = rd_data;
        wcnt++;
        rd_en = 1'b1;
      end else begin
        rd_en = 1'b0;
      end
      idx++;
    end
  endtask

  task automatic start_run(input int tgt);
    @(negedge clk);
    rd_en = 1'b0; run_en = 1'b0;
    @(negedge clk);
    target_count = CW'(tgt);
    run_en = 1'b1;
    idx = 0; wcnt = 0;
  endtask

  // Check npairs pairs; samples either follow idx = k*CPT or equal fixv.
  task automatic verify(input int npairs, input bit fixed, input logic [DW-1:0] fixv,
                        input string req);
    chk(wcnt == 2 * npairs, req, "word count", wcnt, 2 * npairs);
    for (int k = 0; k < npairs && 2 * k + 1 < wcnt; k++) begin
      logic [DW:0] ep, es;
      ep = {1'b1, 16'(k % TPC)};
      es = {1'b0, fixed ? fixv : 16'hA000 + 16'(k * CPT)};
      chk(words[2*k] == ep, req, "position word (R2 R4)", int'(words[2*k]), int'(ep));
      chk(words[2*k+1] == es, req, "sample word (R5 R4)", int'(words[2*k+1]), int'(es));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(rd_empty == 1'b1, "R10", "empty after reset", int'(rd_empty), 1);
    chk(sync_out == 1'b0, "R3", "sync after reset", int'(sync_out), 0);
    chk(overflow == 1'b0, "R8", "overflow after reset", int'(overflow), 0);
    chk(done == 1'b0, "R7", "done after reset", int'(done), 0);

    // R6: idle with ADC active writes nothing
    drain = 1; cycles(30);
    chk(rd_empty == 1'b1 && wcnt == 0, "R6", "idle writes", wcnt, 0);
    chk(sync_out == 1'b0, "R3", "idle sync", int'(sync_out), 0);

    // R1 R2 R3 R4 R5 R7: full sweep with position wrap
    start_run(9);
    sync_lim = 8 * CPT; sync_chk = 1;
    cycles(9 * CPT + 6);
    sync_chk = 0;
    verify(9, 1'b0, '0, "R1");
    chk(done == 1'b1, "R7", "done after target", int'(done), 1);
    cycles(20);
    chk(wcnt == 18, "R7", "no writes after target", wcnt, 18);
    chk(sync_out == 1'b0, "R3", "sync after target", int'(sync_out), 0);

    // R5: adc_valid low, held word used
    @(negedge clk);
    run_en = 1'b0; adc_data = 16'h1234; adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0; vld_mode = 0;
    start_run(3);
    cycles(3 * CPT + 6);
    verify(3, 1'b1, 16'h1234, "R5");
    vld_mode = 1;

    // R6: drop enable mid-run, then restart at position 0
    start_run(20);
    sync_lim = 10; sync_chk = 1;
    cycles(11);
    run_en = 1'b0;
    cycles(20);
    sync_chk = 0;
    verify(3, 1'b0, '0, "R6");
    chk(done == 1'b0, "R6", "done after abort", int'(done), 0);
    start_run(2);
    cycles(2 * CPT + 6);
    verify(2, 1'b0, '0, "R6");

    // R7: zero target
    start_run(0);
    cycles(20);
    chk(done == 1'b1, "R7", "done on zero target", int'(done), 1);
    chk(wcnt == 0 && rd_empty, "R7", "zero target writes", wcnt, 0);

    // R8: overflow without draining
    drain = 0;
    start_run(6);
    cycles(6 * CPT + 4);
    chk(overflow == 1'b1, "R8", "overflow set", int'(overflow), 1);
    chk(fifo_full == 1'b1, "R8", "fifo full", int'(fifo_full), 1);
    chk(done == 1'b1, "R8", "done with skips", int'(done), 1);
    drain = 1;
    cycles(12);
    verify(4, 1'b0, '0, "R8");
    chk(overflow == 1'b1, "R8", "overflow sticky", int'(overflow), 1);
    chk(rd_empty == 1'b1, "R10", "drained", int'(rd_empty), 1);

    // R9: clear flushes leftovers
    drain = 0;
    start_run(2);
    cycles(2 * CPT + 4);
    chk(rd_empty == 1'b0, "R9", "words before clear", int'(rd_empty), 0);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk(rd_empty == 1'b1, "R9", "empty after clear", int'(rd_empty), 1);
    chk(overflow == 1'b0, "R9", "overflow after clear", int'(overflow), 0);
    chk(done == 1'b0, "R9", "done after clear", int'(done), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule